// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block lets software run an 8-bit NAND flash device through a simple synchronous register bus. Each bus phase is started by its own register access. Writing the command register sends one command byte with the command latch high. A trigger bit in the control register sends 1 to 4 address bytes with the address latch high. Other trigger bits clock a counted number of data bytes in from the flash or out to it. Software polls the status word between phases. Each finished phase raises its own sticky done flag, and software clears that flag by writing a one to its bit.

Bytes read from the flash are assembled into 32-bit words, least significant byte first, and are queued in a small read FIFO. Reads of the FIFO register take words out of that queue. Byte counts are held as "count minus one", so a count of 0 moves one byte. The widths of the strobe pulses are programmable. One of four active-low chip enables is asserted at all times, chosen by a bank register. A ready/busy input is synchronised to the clock and reported both as a level and as a sticky rising-edge flag.

Register word addresses are: 0 control triggers, 1 command, 2 address bytes, 3 address count, 4 data count, 5 status, 6 read FIFO, 7 strobe timing, 8 bank, 9 write data. The value read from a register appears on the read data port in the cycle after the read enable.

Top module: `nand_seq`

## Requirements
- R1: After reset the write and read strobes are high, the command latch, address latch and data output enable are low, chip enable 0 alone is asserted, and status reads 0x121 while ready/busy is high (bit 0 level, bits 5 and 8 tied high).
- R2: Writing the command register drives one write-strobe byte with the command latch high, the address latch low and the low 8 bits of the written value on the data bus. At the end of that byte, status bit 2 is set.
- R3: Writing control bit 0 sends (address count + 1) bytes of the address register, starting with bits 7:0, with the address latch high and the command latch low. At the end, status bit 3 is set.
- R4: Writing control bit 1 reads (data count + 1) bytes, each captured at the rising edge of the read strobe. The first byte of each group of four goes to FIFO word bits 7:0. At the end, status bit 4 is set.
- R5: When a read ends partway through a word, that word is queued with its unused upper bytes at zero.
- R6: Writing control bit 2 drives (data count + 1) bytes with both latches low. Byte i is byte (i mod 4) of the write-data register. At the end, status bit 4 is set.
- R7: Writing 1 to status bits 1 to 4 clears those flags. Writing 0 leaves them unchanged.
- R8: A command write or a phase trigger that arrives while a phase is active is ignored and causes no bus activity. When one write sets several trigger bits, address takes priority over read, and read over write.
- R9: Timing register bits 3:0 and 7:4 set the low and high widths of the write strobe. Bits 11:8 and 15:12 set the low and high widths of the read strobe. Widths are in clock cycles, a value of 0 counts as 1, and each reset value is 2. The two strobes are never low at the same time.
- R10: Bank register value n asserts only chip enable n, starting two cycles after the write.
- R11: The read FIFO holds 8 words. A word that arrives when the FIFO is full is dropped. Status bit 6 shows at least 4 words held and bit 9 shows 8 words held. Reading the FIFO when it is empty returns 0. Writing control bit 7 empties it.
- R12: Status bit 0 follows the synchronised ready/busy level. Status bit 1 is set by a rising edge of that level.
- R13: The data output enable is high only while a command, address or write-data phase is active, and never while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable (takes a word from the FIFO at address 6) |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_re |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_re_n | output | 1 | Active-low read strobe |
| fl_ce_n | output | 4 | Active-low chip enables, one per bank |
| fl_dq_o | output | 8 | Data bus output value |
| fl_dq_oe | output | 1 | Data bus output enable (high drives the bus) |
| fl_dq_i | input | 8 | Data bus input value |
| fl_rb | input | 1 | Ready/busy input, high when ready |

## Verification
The assertions assume the following about the inputs:
- the flash holds its data bus steady for the whole low period of the read strobe;
- the ready/busy input changes slowly compared with the synchroniser;
- software changes the timing, bank and count registers only while no phase is active.

The bench's flash model moves to its next data byte only on a rising read strobe, and the bench reprograms registers only after the done flag it polls has been set. Deliberate overlapping triggers are sent only to check R8, and in that test the bench expects the later triggers to produce no bus cycles.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int REG_AW = 4;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_ADDR  = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } phase_e;

  localparam logic [REG_AW-1:0] RA_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] RA_CMD   = 4'd1;
  localparam logic [REG_AW-1:0] RA_ADDR  = 4'd2;
  localparam logic [REG_AW-1:0] RA_ANUM  = 4'd3;
  localparam logic [REG_AW-1:0] RA_DNUM  = 4'd4;
  localparam logic [REG_AW-1:0] RA_STAT  = 4'd5;
  localparam logic [REG_AW-1:0] RA_RFIFO = 4'd6;
  localparam logic [REG_AW-1:0] RA_TIME  = 4'd7;
  localparam logic [REG_AW-1:0] RA_BANK  = 4'd8;
  localparam logic [REG_AW-1:0] RA_WDATA = 4'd9;

  // control trigger bit positions
  localparam int CB_ADDR  = 0;
  localparam int CB_READ  = 1;
  localparam int CB_WRITE = 2;
  localparam int CB_RCLR  = 7;

  // status bit positions
  localparam int SB_RB    = 0;
  localparam int SB_RBD   = 1;
  localparam int SB_CMD   = 2;
  localparam int SB_ADR   = 3;
  localparam int SB_XFR   = 4;
  localparam int SB_WHE   = 5;
  localparam int SB_RHF   = 6;
  localparam int SB_WE    = 8;
  localparam int SB_RFULL = 9;

endpackage

// File: rtl/nand_seq_phy.sv
module nand_seq_phy
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  phase_e           kind_i,
  input  logic [CNT_W-1:0] last_i,
  input  logic [31:0]      word_i,
  input  logic [TW-1:0]    wlo,
  input  logic [TW-1:0]    whi,
  input  logic [TW-1:0]    rlo,
  input  logic [TW-1:0]    rhi,
  input  logic [7:0]       dq_i,
  output logic             busy,
  output logic             done,
  output phase_e           kind_o,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       dq_o,
  output logic             dq_oe,
  output logic             rx_valid,
  output logic [7:0]       rx_byte,
  output logic             rx_last
);

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} st_e;

  st_e              st;
  phase_e           kind_q;
  logic [CNT_W-1:0] idx, last_q, nidx;
  logic [31:0]      word_q;
  logic [TW-1:0]    cnt;
  logic             rd_q;

  function automatic logic [TW-1:0] wid(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  assign nidx   = idx + CNT_W'(1);
  assign rd_q   = (kind_q == PH_READ);
  assign busy   = (st != ST_IDLE);
  assign done   = (st == ST_HI) && (cnt == TW'(1)) && (idx == last_q);
  assign kind_o = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kind_q   <= PH_CMD;
      idx      <= '0;
      last_q   <= '0;
      word_q   <= '0;
      cnt      <= '0;
      cle      <= 1'b0;
      ale      <= 1'b0;
      we_n     <= 1'b1;
      re_n     <= 1'b1;
      dq_o     <= '0;
      dq_oe    <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rx_last  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_LO;
          kind_q <= kind_i;
          last_q <= last_i;
          word_q <= word_i;
          idx    <= '0;
          cle    <= (kind_i == PH_CMD);
          ale    <= (kind_i == PH_ADDR);
          dq_o   <= word_i[7:0];
          if (kind_i == PH_READ) begin
            re_n <= 1'b0;
            cnt  <= wid(rlo);
          end else begin
            we_n  <= 1'b0;
            dq_oe <= 1'b1;
            cnt   <= wid(wlo);
          end
        end
        ST_LO: if (cnt == TW'(1)) begin
          st   <= ST_HI;
          we_n <= 1'b1;
          re_n <= 1'b1;
          cnt  <= rd_q ? wid(rhi) : wid(whi);
          if (rd_q) begin
            rx_valid <= 1'b1;
            rx_byte  <= dq_i;
            rx_last  <= (idx == last_q);
          end
        end else begin
          cnt <= cnt - TW'(1);
        end
        ST_HI: if (cnt == TW'(1)) begin
          if (idx == last_q) begin
            st    <= ST_IDLE;
            cle   <= 1'b0;
            ale   <= 1'b0;
            dq_oe <= 1'b0;
          end else begin
            st   <= ST_LO;
            idx  <= nidx;
            dq_o <= word_q[{nidx[1:0], 3'b000} +: 8];
            if (rd_q) begin
              re_n <= 1'b0;
              cnt  <= wid(rlo);
            end else begin
              we_n <= 1'b0;
              cnt  <= wid(wlo);
            end
          end
        end else begin
          cnt <= cnt - TW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_seq_rfifo.sv
module nand_seq_rfifo #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_last,
  input  logic          pop,
  output logic [31:0]   q,
  output logic [CW-1:0] count,
  output logic          half,
  output logic          full
);

  logic [31:0]   mem [DEPTH];
  logic [31:0]   acc, merged;
  logic [1:0]    bidx;
  logic [CW-1:0] wptr, rptr;
  logic          push, wr_en, empty;

  assign merged = acc | (32'(rx_byte) << {bidx, 3'b000});
  assign push   = rx_valid && (bidx == 2'd3 || rx_last);
  assign count  = wptr - rptr;
  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign half   = (count >= CW'(DEPTH / 2));
  assign wr_en  = push && !full && !clr;

  // byte packer, little-endian
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc  <= '0;
      bidx <= '0;
    end else if (rx_valid) begin
      if (push) begin
        acc  <= '0;
        bidx <= '0;
      end else begin
        acc  <= merged;
        bidx <= bidx + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0]] <= merged;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      q    <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      if (pop) q <= '0;
    end else begin
      if (wr_en) wptr <= wptr + CW'(1);
      if (pop) begin
        q <= empty ? 32'd0 : mem[rptr[AW-1:0]];
        if (!empty) rptr <= rptr + CW'(1);
      end
    end
  end

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int TW         = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int NBANK      = 4,
  localparam int BW        = $clog2(NBANK),
  localparam int RF_CW     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [31:0]       reg_rdata,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic              fl_we_n,
  output logic              fl_re_n,
  output logic [NBANK-1:0]  fl_ce_n,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_i,
  input  logic              fl_rb
);

  logic [31:0]      addr_q, wdata_q, other_q, stat, w1c;
  logic [1:0]       anum_q;
  logic [CNT_W-1:0] dnum_q;
  logic [4*TW-1:0]  time_q;
  logic [BW-1:0]    bank_q;
  logic [REG_AW-1:0] sel_q;
  logic             st_rbd, st_cmd, st_adr, st_xfr;
  logic             rb_s1, rb_s2, rb_s3;
  logic             cmd_wr, ctrl_wr, req, go;
  phase_e           req_kind, ph_kind;
  logic [CNT_W-1:0] req_last;
  logic [31:0]      req_word, rf_q;
  logic             ph_busy, ph_done, rx_valid, rx_last;
  logic [7:0]       rx_byte;
  logic [RF_CW-1:0] rf_count;
  logic             rf_half, rf_full;

  assign cmd_wr  = reg_we && (reg_addr == RA_CMD);
  assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);
  assign w1c     = (reg_we && reg_addr == RA_STAT) ? reg_wdata : 32'd0;

  always_comb begin
    req      = 1'b0;
    req_kind = PH_CMD;
    req_last = '0;
    req_word = '0;
    if (cmd_wr) begin
      req      = 1'b1;
      req_word = {24'd0, reg_wdata[7:0]};
    end else if (ctrl_wr) begin
      if (reg_wdata[CB_ADDR]) begin
        req      = 1'b1;
        req_kind = PH_ADDR;
        req_last = CNT_W'(anum_q);
        req_word = addr_q;
      end else if (reg_wdata[CB_READ]) begin
        req      = 1'b1;
        req_kind = PH_READ;
        req_last = dnum_q;
      end else if (reg_wdata[CB_WRITE]) begin
        req      = 1'b1;
        req_kind = PH_WRITE;
        req_last = dnum_q;
        req_word = wdata_q;
      end
    end
  end
  assign go = req && !ph_busy;

  nand_seq_phy #(.CNT_W(CNT_W), .TW(TW)) u_phy (
    .clk(clk), .rst(rst), .start(go), .kind_i(req_kind), .last_i(req_last),
    .word_i(req_word),
    .wlo(time_q[TW-1:0]), .whi(time_q[2*TW-1:TW]),
    .rlo(time_q[3*TW-1:2*TW]), .rhi(time_q[4*TW-1:3*TW]),
    .dq_i(fl_dq_i), .busy(ph_busy), .done(ph_done), .kind_o(ph_kind),
    .cle(fl_cle), .ale(fl_ale), .we_n(fl_we_n), .re_n(fl_re_n),
    .dq_o(fl_dq_o), .dq_oe(fl_dq_oe),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last)
  );

  nand_seq_rfifo #(.DEPTH(FIFO_DEPTH)) u_rfifo (
    .clk(clk), .rst(rst), .clr(ctrl_wr && reg_wdata[CB_RCLR]),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
    .pop(reg_re && reg_addr == RA_RFIFO),
    .q(rf_q), .count(rf_count), .half(rf_half), .full(rf_full)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      anum_q  <= '0;
      dnum_q  <= '0;
      time_q  <= {4{TW'(2)}};
      bank_q  <= '0;
      wdata_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_ADDR:  addr_q  <= reg_wdata;
        RA_ANUM:  anum_q  <= reg_wdata[1:0];
        RA_DNUM:  dnum_q  <= reg_wdata[CNT_W-1:0];
        RA_TIME:  time_q  <= reg_wdata[4*TW-1:0];
        RA_BANK:  bank_q  <= reg_wdata[BW-1:0];
        RA_WDATA: wdata_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  // ready/busy synchroniser and sticky flags
  always_ff @(posedge clk) begin
    if (rst) begin
      {rb_s1, rb_s2, rb_s3} <= 3'b111;
      {st_rbd, st_cmd, st_adr, st_xfr} <= '0;
    end else begin
      rb_s1  <= fl_rb;
      rb_s2  <= rb_s1;
      rb_s3  <= rb_s2;
      st_rbd <= (rb_s2 && !rb_s3) || (st_rbd && !w1c[SB_RBD]);
      st_cmd <= (ph_done && ph_kind == PH_CMD) || (st_cmd && !w1c[SB_CMD]);
      st_adr <= (ph_done && ph_kind == PH_ADDR) || (st_adr && !w1c[SB_ADR]);
      st_xfr <= (ph_done && (ph_kind == PH_READ || ph_kind == PH_WRITE))
                || (st_xfr && !w1c[SB_XFR]);
    end
  end

  always_comb begin
    stat           = '0;
    stat[SB_RB]    = rb_s2;
    stat[SB_RBD]   = st_rbd;
    stat[SB_CMD]   = st_cmd;
    stat[SB_ADR]   = st_adr;
    stat[SB_XFR]   = st_xfr;
    stat[SB_WHE]   = 1'b1;
    stat[SB_RHF]   = rf_half;
    stat[SB_WE]    = 1'b1;
    stat[SB_RFULL] = rf_full;
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= RA_CTRL;
      other_q <= '0;
    end else if (reg_re) begin
      sel_q <= reg_addr;
      case (reg_addr)
        RA_ADDR:  other_q <= addr_q;
        RA_ANUM:  other_q <= 32'(anum_q);
        RA_DNUM:  other_q <= 32'(dnum_q);
        RA_STAT:  other_q <= stat;
        RA_TIME:  other_q <= 32'(time_q);
        RA_BANK:  other_q <= 32'(bank_q);
        RA_WDATA: other_q <= wdata_q;
        default:  other_q <= '0;
      endcase
    end
  end
  assign reg_rdata = (sel_q == RA_RFIFO) ? rf_q : other_q;

  // one registered active-low enable per bank
  for (genvar g = 0; g < NBANK; g++) begin : g_ce
    always_ff @(posedge clk) begin
      if (rst) fl_ce_n[g] <= (g != 0);
      else     fl_ce_n[g] <= (bank_q != BW'(g));
    end
  end

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int NBANK = 4,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             fl_we_n,
  input logic             fl_re_n,
  input logic             fl_cle,
  input logic             fl_ale,
  input logic             fl_dq_oe,
  input logic [NBANK-1:0] fl_ce_n,
  input logic             st_cmd,
  input logic [CW-1:0]    rf_count
);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_re_n));

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(fl_cle && fl_ale));

  p_one_bank_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(~fl_ce_n) == 1);

  p_oe_off_read_r13: assert property (@(posedge clk) disable iff (rst)
    !fl_re_n |-> !fl_dq_oe);

  p_cmd_flag_end_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(st_cmd) |-> $fell(fl_cle));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    rf_count <= CW'(DEPTH));

endmodule

bind nand_seq nand_seq_chk #(.NBANK(NBANK), .DEPTH(FIFO_DEPTH), .CW(RF_CW)) u_chk (
  .clk(clk), .rst(rst), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
  .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n),
  .st_cmd(st_cmd), .rf_count(rf_count)
);

// File: tb/tb_nand_seq.sv
module tb_nand_seq;
  import nand_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_we, reg_re;
  logic        fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe, fl_rb;
  logic [3:0]  fl_ce_n;
  logic [7:0]  fl_dq_o, fl_dq_i;

  always #2 clk = ~clk;

  nand_seq dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
    .fl_ce_n(fl_ce_n), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_dq_i(fl_dq_i), .fl_rb(fl_rb)
  );

  int errs = 0;
  int checks = 0;
  logic [9:0] exp_q[$];
  int ridx = 0;
  int exp_we_lo = 2;

  // flash model: next byte only after a rising read strobe
  function automatic logic [7:0] romb(input int i);
    return 8'((i * 37 + 90) % 256);
  endfunction
  assign fl_dq_i = romb(ridx);
  always @(posedge fl_re_n) ridx <= ridx + 1;

  function automatic logic [31:0] word(input int b, input int n);
    logic [31:0] w = '0;
    for (int k = 0; k < n; k++) w[8*k +: 8] = romb(b + k);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every write-strobe rising edge pops one expected bus cycle
  logic prev_we = 1'b1;
  int   we_low = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!fl_re_n) chk(!fl_dq_oe, "R13 oe during read", 32'(fl_dq_oe), 0);
      if (!fl_we_n) we_low++;
      else if (!prev_we) begin
        chk(we_low == exp_we_lo, "R9 write strobe low width", we_low, exp_we_lo);
        chk(fl_dq_oe, "R13 oe on write byte", 32'(fl_dq_oe), 1);
        if (exp_q.size() == 0)
          chk(1'b0, "R8 unexpected bus write", {fl_cle, fl_ale, fl_dq_o}, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({fl_cle, fl_ale, fl_dq_o} == e, "bus byte R2 R3 R6",
              {fl_cle, fl_ale, fl_dq_o}, e);
        end
        we_low = 0;
      end
      prev_we = fl_we_n;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic poll(input int b, input string tag);
    logic [31:0] v;
    int n = 0;
    do begin
      rd(RA_STAT, v);
      n++;
    end while (!v[b] && n < 300);
    chk(v[b], tag, v, 32'(1) << b);
    wr(RA_STAT, 32'(1) << b);
  endtask

  task automatic push(input bit c, input bit a, input logic [7:0] b);
    exp_q.push_back({c, a, b});
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    int base;
    logic pat [9];
    rst = 1'b1; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0; reg_re = 1'b0;
    fl_rb = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(fl_we_n && fl_re_n && !fl_cle && !fl_ale && !fl_dq_oe, "R1 idle pins",
        {fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe}, 5'b11000);
    chk(fl_ce_n == 4'b1110, "R1 chip enable", fl_ce_n, 4'b1110);
    rd(RA_STAT, v);
    chk(v == 32'h121, "R1 status", v, 32'h121);

    // R10 bank select
    wr(RA_BANK, 2); @(negedge clk);
    chk(fl_ce_n == 4'b1011, "R10 bank 2", fl_ce_n, 4'b1011);
    wr(RA_BANK, 3); @(negedge clk);
    chk(fl_ce_n == 4'b0111, "R10 bank 3", fl_ce_n, 4'b0111);
    wr(RA_BANK, 0); @(negedge clk);
    chk(fl_ce_n == 4'b1110, "R10 bank 0", fl_ce_n, 4'b1110);

    // R2 + R7 command cycle and write-one-to-clear
    push(1, 0, 8'h90);
    wr(RA_CMD, 32'h90);
    do rd(RA_STAT, v); while (!v[SB_CMD]);
    chk(v[SB_CMD], "R2 command done", v, 32'h4);
    wr(RA_STAT, 0); rd(RA_STAT, v);
    chk(v[SB_CMD], "R7 zero write keeps flag", v[SB_CMD], 1);
    wr(RA_STAT, 4); rd(RA_STAT, v);
    chk(!v[SB_CMD], "R7 one write clears flag", v[SB_CMD], 0);
    chk(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);

    // R3 single address byte, R4 four-byte read
    push(0, 1, 8'h00);
    wr(RA_ADDR, 0); wr(RA_ANUM, 0); wr(RA_CTRL, 1);
    poll(SB_ADR, "R3 address done");
    base = ridx;
    wr(RA_DNUM, 3); wr(RA_CTRL, 2);
    poll(SB_XFR, "R4 transfer done");
    rd(RA_RFIFO, v);
    chk(v == word(base, 4), "R4 packed word", v, word(base, 4));
    rd(RA_RFIFO, v);
    chk(v == 0, "R11 empty read", v, 0);

    // R3 four address bytes
    for (int k = 0; k < 4; k++) push(0, 1, 8'(8'h11 * (k + 1)));
    wr(RA_ADDR, 32'h44332211); wr(RA_ANUM, 3); wr(RA_CTRL, 1);
    poll(SB_ADR, "R3 address done x4");
    chk(exp_q.size() == 0, "R3 four bytes seen", exp_q.size(), 0);

    // R8 triggers while busy
    push(1, 0, 8'hA1);
    wr(RA_CMD, 32'hA1); wr(RA_CMD, 32'hB2); wr(RA_CTRL, 1);
    poll(SB_CMD, "R8 command done");
    rd(RA_STAT, v);
    chk(!v[SB_ADR], "R8 ignored address trigger", v, 0);
    chk(exp_q.size() == 0, "R8 no missing byte", exp_q.size(), 0);

    // R6 write phase
    wr(RA_WDATA, 32'hDDCCBBAA); wr(RA_DNUM, 5);
    push(0, 0, 8'hAA); push(0, 0, 8'hBB); push(0, 0, 8'hCC);
    push(0, 0, 8'hDD); push(0, 0, 8'hAA); push(0, 0, 8'hBB);
    wr(RA_CTRL, 4);
    poll(SB_XFR, "R6 transfer done");
    chk(exp_q.size() == 0, "R6 six bytes seen", exp_q.size(), 0);
    chk(!fl_dq_oe, "R13 oe idle", 32'(fl_dq_oe), 0);

    // R5 partial word
    base = ridx;
    wr(RA_DNUM, 5); wr(RA_CTRL, 2);
    poll(SB_XFR, "R5 transfer done");
    rd(RA_RFIFO, v);
    chk(v == word(base, 4), "R5 first word", v, word(base, 4));
    rd(RA_RFIFO, v);
    chk(v == word(base + 4, 2), "R5 zero-filled word", v, word(base + 4, 2));

    // R11 fill levels, overflow drop, clear
    wr(RA_CTRL, 32'h80);
    base = ridx;
    wr(RA_DNUM, 15); wr(RA_CTRL, 2);
    poll(SB_XFR, "R11 transfer done");
    rd(RA_STAT, v);
    chk(v[SB_RHF] && !v[SB_RFULL], "R11 half full", v, 32'h40);
    wr(RA_DNUM, 19); wr(RA_CTRL, 2);
    poll(SB_XFR, "R11 transfer done 2");
    rd(RA_STAT, v);
    chk(v[SB_RFULL], "R11 full", v, 32'h200);
    for (int k = 0; k < 8; k++) begin
      rd(RA_RFIFO, v);
      chk(v == word(base + 4 * k, 4), "R11 word order", v, word(base + 4 * k, 4));
    end
    rd(RA_RFIFO, v);
    chk(v == 0, "R11 ninth word dropped", v, 0);
    wr(RA_DNUM, 3); wr(RA_CTRL, 2);
    poll(SB_XFR, "R11 transfer done 3");
    wr(RA_CTRL, 32'h80);
    rd(RA_RFIFO, v);
    chk(v == 0, "R11 clear empties", v, 0);
    rd(RA_STAT, v);
    chk(!v[SB_RHF] && !v[SB_RFULL], "R11 levels after clear", v, 0);

    // R9 read strobe timing: low 3, high 1
    wr(RA_TIME, 32'h1322);
    base = ridx;
    wr(RA_DNUM, 1);
    wr(RA_CTRL, 2);
    pat[0] = fl_re_n;
    for (int k = 1; k < 9; k++) begin
      @(negedge clk);
      pat[k] = fl_re_n;
    end
    for (int k = 0; k < 9; k++) begin
      logic e;
      e = (k == 3 || k >= 7);
      chk(pat[k] == e, "R9 read strobe pattern", 32'(pat[k]), 32'(e));
    end
    poll(SB_XFR, "R9 transfer done");
    rd(RA_RFIFO, v);
    chk(v == word(base, 2), "R9 bytes under new timing", v, word(base, 2));
    wr(RA_TIME, 32'h2222);

    // R12 ready/busy
    fl_rb = 1'b0;
    repeat (4) @(negedge clk);
    rd(RA_STAT, v);
    chk(!v[SB_RB] && !v[SB_RBD], "R12 busy level", v[1:0], 0);
    fl_rb = 1'b1;
    repeat (4) @(negedge clk);
    rd(RA_STAT, v);
    chk(v[SB_RB] && v[SB_RBD], "R12 ready edge flag", v[1:0], 3);
    wr(RA_STAT, 2);
    rd(RA_STAT, v);
    chk(!v[SB_RBD], "R12 flag cleared", v[1:0], 1);

    summary();
  end

endmodule